// File: doc/BRIEF.md
# Multi-Channel DMA Network Interface Register Bank

This block is the software-visible control plane of a multi-channel DMA network interface. A simple strobe/acknowledge slave port reaches a banked register file. The address bits above the low nibble pick a virtual channel, and the low nibble picks a register inside that channel. Low-nibble value zero opens a shared bank instead. That bank holds a summary status word and the global burst size.

Each channel holds the send configuration and the receive configuration. It also holds the header fields captured from the last arriving packet, and a 14-bit word that mixes busy bits, interrupt enables and sticky cause flags. The DMA engines sit outside the block. They report progress through per-channel event pulses and busy levels, and they read their configuration from flattened output buses.

Each channel also contains a small receive-address generator. It turns the buffer pointer, the start index and the buffer limit into a wrapping write address. It also produces a keep flag that drops words arriving past the buffer limit. Enabled causes from all channels are ORed into one interrupt line.

Top module: `ni_regbank`

## Requirements
- R1: A strobe is acknowledged on the next clock with a one-cycle `ack_o` pulse. While the strobe stays high the acknowledge alternates, and a write takes effect once per acknowledge.
- R2: `addr_i[3:0]` selects the register and `addr_i` from bit 4 upward selects the channel. Each channel's writable registers read back what was written: 2 destination, 3 send pointer, 4 send size, 5 send header data, 9 receive pointer, 11 buffer limit in words, 12 start index, 13 receive control. Writing one channel leaves the other channels unchanged.
- R3: Register offset 0 is the shared bank, and `addr_i[5:4]` selects within it: 0 is the status word, 1 is the burst size. The status word is {send grant index, receive grant index, any-error, any-got, any-saved, any-sent}. The four flags sit in bits 3..0, and each is the OR across channels.
- R4: The burst size resets to all ones. A write to it is ignored while any channel's `send_busy_i` is high.
- R5: Flag word (offset 1), by bit: 0 send busy, 1 receive busy, 2..5 enables for sent, saved, got and error. Bits 6..12 are sticky causes set by event bits 0..6 (0 sent, 1 saved, 2 got, 3 overflow, 4 CRC mismatch, 5 size error, 6 burst error). Bit 13 is the invalid-send-request flag.
- R6: Writing 1 to a sticky bit clears it. An event in the same cycle as the clear wins, so the flag stays set.
- R7: `irq_o` is high when any channel has a sent, saved or got flag with its enable set, or has any of bits 9..13 set with the error enable set.
- R8: Writes to offsets 2..5 are ignored while that channel's send is busy. An accepted write to offset 4 raises that channel's `send_start_o` for one cycle. A write to offset 4 while busy raises no start and sets flag bit 13.
- R9: `hdr_save_i` captures the source, class, header data and pre-captured data. Offset 8 reads the source in bits 7:0, the class from bit 16 and header bits 7:0 in bits 31:24. Offset 14 reads the pre-captured data. Offset 10 reads the size sampled from `rx_size_i` on the got event.
- R10: `recv_begin_i` sets the word index to the start index, or to 0 if the start index is not below the limit. The write address is pointer + 4 × index. Each kept word advances the index, wrapping to 0 at the limit. After limit words `recv_keep_o` falls and the address holds.
- R11: Offsets 6, 7 and 15, and shared sub-addresses 2 and 3, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stb_i | input | 1 | Access strobe |
| we_i | input | 1 | Write enable |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current address |
| ack_o | output | 1 | Access acknowledge |
| send_busy_i | input | NUM_CH | Per-channel send engine busy |
| recv_busy_i | input | NUM_CH | Per-channel receive engine busy |
| send_grant_i | input | CH_W | Index of the channel granted to send |
| recv_grant_i | input | CH_W | Index of the channel granted to receive |
| events_i | input | NUM_CH*7 | Per-channel event pulses, 7 bits each |
| hdr_save_i | input | NUM_CH | Capture header fields into a channel |
| hdr_src_i | input | EADDR_W | Received source address |
| hdr_class_i | input | CLASS_W | Received packet class |
| hdr_data_i | input | HDR_W | Received header data |
| precap_i | input | PRECAP_W | Pre-captured header data |
| rx_size_i | input | SIZE_W+2 | Received size in bytes |
| recv_begin_i | input | NUM_CH | Start of a receive transfer |
| recv_word_i | input | NUM_CH | One received word presented |
| send_start_o | output | NUM_CH | Send start pulse |
| send_dest_o | output | NUM_CH*EADDR_W | Send destinations |
| send_ptr_o | output | NUM_CH*32 | Send byte pointers |
| send_size_o | output | NUM_CH*SIZE_W | Send sizes in bytes |
| send_hdr_o | output | NUM_CH*HDR_W | Send header data |
| burst_o | output | BURST_W | Global burst size |
| recv_ctrl_o | output | NUM_CH*8 | Receive control bytes |
| recv_addr_o | output | NUM_CH*32 | Receive write byte addresses |
| recv_keep_o | output | NUM_CH | Current receive word is stored |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench builds the block with two channels, an 8-bit endpoint address, a 10-bit size field and a 9-bit burst size. With these values the channel field is address bit 4, which is also the low bit of the shared sub-address. This makes the overlap between the channel select and the shared bank decode directly observable. A buffer limit of four words lets the receive index wrap and then reach the discard point within a handful of word pulses.

// File: rtl/ni_regbank_pkg.sv
package ni_regbank_pkg;
  localparam int FLAG_W = 14;
  localparam int EVT_W  = 7;
  localparam int STK_W  = 8;

  localparam logic [3:0] OFF_SHARED = 4'd0;
  localparam logic [3:0] OFF_FLAGS  = 4'd1;
  localparam logic [3:0] OFF_S_DEST = 4'd2;
  localparam logic [3:0] OFF_S_PTR  = 4'd3;
  localparam logic [3:0] OFF_S_SIZE = 4'd4;
  localparam logic [3:0] OFF_S_HDR  = 4'd5;
  localparam logic [3:0] OFF_R_SRC  = 4'd8;
  localparam logic [3:0] OFF_R_PTR  = 4'd9;
  localparam logic [3:0] OFF_R_SIZE = 4'd10;
  localparam logic [3:0] OFF_R_MAX  = 4'd11;
  localparam logic [3:0] OFF_R_IDX  = 4'd12;
  localparam logic [3:0] OFF_R_CTRL = 4'd13;
  localparam logic [3:0] OFF_R_PRE  = 4'd14;

  localparam logic [1:0] SUB_STATUS = 2'd0;
  localparam logic [1:0] SUB_BURST  = 2'd1;

  // sticky index: 0 sent,1 saved,2 got,3 ovf,4 crc,5 size,6 burst,7 bad request
  localparam int STK_GOT = 2;
  localparam int STK_ERR_LO = 3;
endpackage

// File: rtl/ni_rx_addr_gen.sv
module ni_rx_addr_gen #(
  parameter int SIZE_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              begin_i,
  input  logic              word_i,
  input  logic [31:0]       base_i,
  input  logic [SIZE_W-1:0] max_i,
  input  logic [SIZE_W-1:0] start_i,
  output logic [31:0]       addr_o,
  output logic              keep_o
);
  logic [SIZE_W-1:0] idx_q, cnt_q;
  logic [SIZE_W:0]   idx_inc;

  assign idx_inc = {1'b0, idx_q} + 1'b1;
  assign keep_o  = cnt_q < max_i;
  assign addr_o  = base_i + 32'({idx_q, 2'b00});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (begin_i) begin
      idx_q <= (start_i < max_i) ? start_i : '0;
      cnt_q <= '0;
    end else if (word_i && keep_o) begin
      cnt_q <= cnt_q + 1'b1;
      idx_q <= (idx_inc == {1'b0, max_i}) ? '0 : idx_inc[SIZE_W-1:0];
    end
  end
endmodule

// File: rtl/ni_bank_ctrl.sv
module ni_bank_ctrl #(
  parameter int BURST_W = 9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stb_i,
  input  logic               we_i,
  input  logic               burst_sel_i,
  input  logic               send_busy_any_i,
  input  logic [BURST_W-1:0] burst_wdata_i,
  output logic               ack_o,
  output logic               commit_o,
  output logic [BURST_W-1:0] burst_o
);
  // one commit per acknowledge: side effects fire once
  assign commit_o = stb_i & we_i & ~ack_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      burst_o <= '1;
    end else begin
      ack_o <= stb_i & ~ack_o;
      if (commit_o && burst_sel_i && !send_busy_any_i) burst_o <= burst_wdata_i;
    end
  end
endmodule

// File: rtl/ni_chan_regs.sv
module ni_chan_regs
  import ni_regbank_pkg::*;
#(
  parameter int EADDR_W  = 8,
  parameter int CLASS_W  = 2,
  parameter int HDR_W    = 8,
  parameter int PRECAP_W = 8,
  parameter int SIZE_W   = 10,
  parameter int RX_W     = SIZE_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [3:0]          off_i,
  input  logic [31:0]         wdata_i,
  input  logic                send_busy_i,
  input  logic                recv_busy_i,
  input  logic [EVT_W-1:0]    evt_i,
  input  logic                hdr_save_i,
  input  logic [EADDR_W-1:0]  hdr_src_i,
  input  logic [CLASS_W-1:0]  hdr_class_i,
  input  logic [HDR_W-1:0]    hdr_data_i,
  input  logic [PRECAP_W-1:0] precap_i,
  input  logic [RX_W-1:0]     rx_size_i,
  input  logic                recv_begin_i,
  input  logic                recv_word_i,
  output logic                send_start_o,
  output logic [EADDR_W-1:0]  send_dest_o,
  output logic [31:0]         send_ptr_o,
  output logic [SIZE_W-1:0]   send_size_o,
  output logic [HDR_W-1:0]    send_hdr_o,
  output logic [7:0]          recv_ctrl_o,
  output logic [31:0]         recv_addr_o,
  output logic                recv_keep_o,
  output logic [STK_W-1:0]    sticky_o,
  output logic                irq_o,
  output logic [31:0]         rdata_o
);
  logic [31:0]         rptr_q;
  logic [SIZE_W-1:0]   rmax_q, ridx_q;
  logic [EADDR_W-1:0]  src_q;
  logic [CLASS_W-1:0]  cls_q;
  logic [HDR_W-1:0]    rhdr_q;
  logic [PRECAP_W-1:0] pre_q;
  logic [RX_W-1:0]     rsize_q;
  logic [3:0]          en_q;
  logic [STK_W-1:0]    stk_nx;
  logic [7:0]          hdr_lo;
  logic                wr_send, bad_req;
  logic                unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr_send = wr_i & ~send_busy_i;
  assign bad_req = wr_i & send_busy_i & (off_i == OFF_S_SIZE);

  always_comb begin
    stk_nx = sticky_o;
    if (wr_i && off_i == OFF_FLAGS) stk_nx = stk_nx & ~wdata_i[13:6];
    stk_nx = stk_nx | {bad_req, evt_i};  // set wins over clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      send_dest_o  <= '0;
      send_ptr_o   <= '0;
      send_size_o  <= '0;
      send_hdr_o   <= '0;
      send_start_o <= 1'b0;
      rptr_q       <= '0;
      rmax_q       <= '0;
      ridx_q       <= '0;
      recv_ctrl_o  <= '0;
      en_q         <= '0;
      sticky_o     <= '0;
      src_q        <= '0;
      cls_q        <= '0;
      rhdr_q       <= '0;
      pre_q        <= '0;
      rsize_q      <= '0;
    end else begin
      send_start_o <= wr_send && (off_i == OFF_S_SIZE);
      sticky_o     <= stk_nx;
      if (wr_send) begin
        case (off_i)
          OFF_S_DEST: send_dest_o <= wdata_i[EADDR_W-1:0];
          OFF_S_PTR:  send_ptr_o  <= wdata_i;
          OFF_S_SIZE: send_size_o <= wdata_i[SIZE_W-1:0];
          OFF_S_HDR:  send_hdr_o  <= wdata_i[HDR_W-1:0];
          default: ;
        endcase
      end
      if (wr_i) begin
        case (off_i)
          OFF_FLAGS:  en_q        <= wdata_i[5:2];
          OFF_R_PTR:  rptr_q      <= wdata_i;
          OFF_R_MAX:  rmax_q      <= wdata_i[SIZE_W-1:0];
          OFF_R_IDX:  ridx_q      <= wdata_i[SIZE_W-1:0];
          OFF_R_CTRL: recv_ctrl_o <= wdata_i[7:0];
          default: ;
        endcase
      end
      if (hdr_save_i) begin
        src_q  <= hdr_src_i;
        cls_q  <= hdr_class_i;
        rhdr_q <= hdr_data_i;
        pre_q  <= precap_i;
      end
      if (evt_i[STK_GOT]) rsize_q <= rx_size_i;
    end
  end

  assign irq_o = (|sticky_o[STK_W-1:STK_ERR_LO] & en_q[3]) |
                 (|(sticky_o[2:0] & en_q[2:0]));

  generate
    if (HDR_W >= 8) begin : g_hdr_wide
      assign hdr_lo = rhdr_q[7:0];
    end else begin : g_hdr_narrow
      assign hdr_lo = {{(8 - HDR_W){1'b0}}, rhdr_q};
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_FLAGS:  rdata_o = 32'({sticky_o, en_q, recv_busy_i, send_busy_i});
      OFF_S_DEST: rdata_o = 32'(send_dest_o);
      OFF_S_PTR:  rdata_o = send_ptr_o;
      OFF_S_SIZE: rdata_o = 32'(send_size_o);
      OFF_S_HDR:  rdata_o = 32'(send_hdr_o);
      OFF_R_SRC: begin
        rdata_o[EADDR_W-1:0]    = src_q;
        rdata_o[16 +: CLASS_W]  = cls_q;
        rdata_o[31:24]          = hdr_lo;
      end
      OFF_R_PTR:  rdata_o = rptr_q;
      OFF_R_SIZE: rdata_o = 32'(rsize_q);
      OFF_R_MAX:  rdata_o = 32'(rmax_q);
      OFF_R_IDX:  rdata_o = 32'(ridx_q);
      OFF_R_CTRL: rdata_o = 32'(recv_ctrl_o);
      OFF_R_PRE:  rdata_o = 32'(pre_q);
      default:    rdata_o = '0;
    endcase
  end

  ni_rx_addr_gen #(.SIZE_W(SIZE_W)) i_rx_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .begin_i (recv_begin_i),
    .word_i  (recv_word_i),
    .base_i  (rptr_q),
    .max_i   (rmax_q),
    .start_i (ridx_q),
    .addr_o  (recv_addr_o),
    .keep_o  (recv_keep_o)
  );
endmodule

// File: rtl/ni_regbank.sv
module ni_regbank
  import ni_regbank_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int EADDR_W  = 8,
  parameter int CLASS_W  = 2,
  parameter int HDR_W    = 8,
  parameter int PRECAP_W = 8,
  parameter int SIZE_W   = 10,
  parameter int BURST_W  = 9,
  parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int ADDR_W   = 4 + ((CH_W > 2) ? CH_W : 2)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        stb_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic                        ack_o,
  input  logic [NUM_CH-1:0]           send_busy_i,
  input  logic [NUM_CH-1:0]           recv_busy_i,
  input  logic [CH_W-1:0]             send_grant_i,
  input  logic [CH_W-1:0]             recv_grant_i,
  input  logic [NUM_CH*7-1:0]         events_i,
  input  logic [NUM_CH-1:0]           hdr_save_i,
  input  logic [EADDR_W-1:0]          hdr_src_i,
  input  logic [CLASS_W-1:0]          hdr_class_i,
  input  logic [HDR_W-1:0]            hdr_data_i,
  input  logic [PRECAP_W-1:0]         precap_i,
  input  logic [SIZE_W+1:0]           rx_size_i,
  input  logic [NUM_CH-1:0]           recv_begin_i,
  input  logic [NUM_CH-1:0]           recv_word_i,
  output logic [NUM_CH-1:0]           send_start_o,
  output logic [NUM_CH*EADDR_W-1:0]   send_dest_o,
  output logic [NUM_CH*32-1:0]        send_ptr_o,
  output logic [NUM_CH*SIZE_W-1:0]    send_size_o,
  output logic [NUM_CH*HDR_W-1:0]     send_hdr_o,
  output logic [BURST_W-1:0]          burst_o,
  output logic [NUM_CH*8-1:0]         recv_ctrl_o,
  output logic [NUM_CH*32-1:0]        recv_addr_o,
  output logic [NUM_CH-1:0]           recv_keep_o,
  output logic                        irq_o
);
  localparam int SLOTS  = 1 << CH_W;
  localparam int STAT_W = 2 * CH_W + 4;

  logic [3:0]        off;
  logic [1:0]        sub;
  logic [CH_W-1:0]   ch_idx;
  logic              commit, burst_sel;
  logic [NUM_CH-1:0] chan_wr, chan_irq;
  logic [STK_W-1:0]  chan_stk [NUM_CH];
  logic [31:0]       chan_rd  [NUM_CH];
  logic [31:0]       slot_rd  [SLOTS];
  logic [STAT_W-1:0] status;
  logic [3:0]        any_flag;
  logic              unused_addr;

  assign off         = addr_i[3:0];
  assign sub         = addr_i[5:4];
  assign ch_idx      = addr_i[4 +: CH_W];
  assign unused_addr = ^addr_i;
  assign burst_sel   = (off == OFF_SHARED) && (sub == SUB_BURST);

  ni_bank_ctrl #(.BURST_W(BURST_W)) i_bank (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .stb_i           (stb_i),
    .we_i            (we_i),
    .burst_sel_i     (burst_sel),
    .send_busy_any_i (|send_busy_i),
    .burst_wdata_i   (wdata_i[BURST_W-1:0]),
    .ack_o           (ack_o),
    .commit_o        (commit),
    .burst_o         (burst_o)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign chan_wr[i] = commit && (off != OFF_SHARED) && (ch_idx == CH_W'(i));
      ni_chan_regs #(
        .EADDR_W (EADDR_W), .CLASS_W (CLASS_W), .HDR_W (HDR_W),
        .PRECAP_W(PRECAP_W), .SIZE_W (SIZE_W)
      ) i_chan (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_i         (chan_wr[i]),
        .off_i        (off),
        .wdata_i      (wdata_i),
        .send_busy_i  (send_busy_i[i]),
        .recv_busy_i  (recv_busy_i[i]),
        .evt_i        (events_i[i*EVT_W +: EVT_W]),
        .hdr_save_i   (hdr_save_i[i]),
        .hdr_src_i    (hdr_src_i),
        .hdr_class_i  (hdr_class_i),
        .hdr_data_i   (hdr_data_i),
        .precap_i     (precap_i),
        .rx_size_i    (rx_size_i),
        .recv_begin_i (recv_begin_i[i]),
        .recv_word_i  (recv_word_i[i]),
        .send_start_o (send_start_o[i]),
        .send_dest_o  (send_dest_o[i*EADDR_W +: EADDR_W]),
        .send_ptr_o   (send_ptr_o[i*32 +: 32]),
        .send_size_o  (send_size_o[i*SIZE_W +: SIZE_W]),
        .send_hdr_o   (send_hdr_o[i*HDR_W +: HDR_W]),
        .recv_ctrl_o  (recv_ctrl_o[i*8 +: 8]),
        .recv_addr_o  (recv_addr_o[i*32 +: 32]),
        .recv_keep_o  (recv_keep_o[i]),
        .sticky_o     (chan_stk[i]),
        .irq_o        (chan_irq[i]),
        .rdata_o      (chan_rd[i])
      );
    end
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s < NUM_CH) begin : g_live
        assign slot_rd[s] = chan_rd[s];
      end else begin : g_hole
        assign slot_rd[s] = '0;
      end
    end
  endgenerate

  always_comb begin
    any_flag = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      any_flag[3] = any_flag[3] | (|chan_stk[i][STK_W-1:STK_ERR_LO]);
      any_flag[2] = any_flag[2] | chan_stk[i][2];
      any_flag[1] = any_flag[1] | chan_stk[i][1];
      any_flag[0] = any_flag[0] | chan_stk[i][0];
    end
  end

  assign status = {send_grant_i, recv_grant_i, any_flag};
  assign irq_o  = |chan_irq;

  always_comb begin
    rdata_o = '0;
    if (off == OFF_SHARED) begin
      case (sub)
        SUB_STATUS: rdata_o = 32'(status);
        SUB_BURST:  rdata_o = 32'(burst_o);
        default:    rdata_o = '0;
      endcase
    end else begin
      rdata_o = slot_rd[ch_idx];
    end
  end
endmodule

// File: rtl/ni_regbank_chk.sv
module ni_regbank_chk #(
  parameter int NUM_CH  = 2,
  parameter int BURST_W = 9,
  parameter int ADDR_W  = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 stb_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [31:0]          rdata_o,
  input logic                 ack_o,
  input logic [NUM_CH-1:0]    send_busy_i,
  input logic [NUM_CH-1:0]    send_start_o,
  input logic [BURST_W-1:0]   burst_o,
  input logic [NUM_CH-1:0]    recv_begin_i,
  input logic [NUM_CH-1:0]    recv_keep_o,
  input logic [NUM_CH*32-1:0] recv_addr_o
);
  AST_ACK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);  // R1
  AST_ACK_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !ack_o) |=> ack_o);  // R1
  AST_BURST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|send_busy_i) |=> $stable(burst_o));  // R4
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|send_start_o) |-> ((send_start_o & $past(send_busy_i)) == '0));  // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && (addr_i[3:0] == 4'd6 || addr_i[3:0] == 4'd7 || addr_i[3:0] == 4'd15))
      |-> (rdata_o == 32'd0));  // R11
  for (genvar c = 0; c < NUM_CH; c++) begin : g_rx
    AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!recv_keep_o[c] && !recv_begin_i[c] && !stb_i)
        |=> $stable(recv_addr_o[c*32 +: 32]));  // R10
  end
endmodule

bind ni_regbank ni_regbank_chk #(.NUM_CH(NUM_CH), .BURST_W(BURST_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stb_i        (stb_i),
  .addr_i       (addr_i),
  .rdata_o      (rdata_o),
  .ack_o        (ack_o),
  .send_busy_i  (send_busy_i),
  .send_start_o (send_start_o),
  .burst_o      (burst_o),
  .recv_begin_i (recv_begin_i),
  .recv_keep_o  (recv_keep_o),
  .recv_addr_o  (recv_addr_o)
);

// File: tb/test_ni_regbank.sv
module test_ni_regbank;
  localparam int NUM_CH = 2, EADDR_W = 8, CLASS_W = 2, HDR_W = 8, PRECAP_W = 8;
  localparam int SIZE_W = 10, BURST_W = 9, CH_W = 1, ADDR_W = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic stb_i = 0, we_i = 0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic ack_o;
  logic [NUM_CH-1:0] send_busy_i = '0, recv_busy_i = '0;
  logic [CH_W-1:0] send_grant_i = '0, recv_grant_i = '0;
  logic [NUM_CH*7-1:0] events_i = '0;
  logic [NUM_CH-1:0] hdr_save_i = '0, recv_begin_i = '0, recv_word_i = '0;
  logic [EADDR_W-1:0] hdr_src_i = '0;
  logic [CLASS_W-1:0] hdr_class_i = '0;
  logic [HDR_W-1:0] hdr_data_i = '0;
  logic [PRECAP_W-1:0] precap_i = '0;
  logic [SIZE_W+1:0] rx_size_i = '0;
  logic [NUM_CH-1:0] send_start_o, recv_keep_o;
  logic [NUM_CH*EADDR_W-1:0] send_dest_o;
  logic [NUM_CH*32-1:0] send_ptr_o, recv_addr_o;
  logic [NUM_CH*SIZE_W-1:0] send_size_o;
  logic [NUM_CH*HDR_W-1:0] send_hdr_o;
  logic [BURST_W-1:0] burst_o;
  logic [NUM_CH*8-1:0] recv_ctrl_o;
  logic irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk_i = ~clk_i;

  ni_regbank #(
    .NUM_CH(NUM_CH), .EADDR_W(EADDR_W), .CLASS_W(CLASS_W), .HDR_W(HDR_W),
    .PRECAP_W(PRECAP_W), .SIZE_W(SIZE_W), .BURST_W(BURST_W)
  ) i_ni_regbank (.*);

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read as it is acknowledged
  always @(negedge clk_i) begin
    if (rst_ni && ack_o && stb_i && !we_i) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R1: unexpected read ack, actual %h expected none", rdata_o);
      end else begin
        check(rdata_o, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk_i); stb_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i); #1 stb_i = 0;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk_i); stb_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); #1 stb_i = 0; we_i = 0;
  endtask

  task automatic pulse_evt(input int b);
    @(negedge clk_i); events_i[b] = 1'b1;
    @(negedge clk_i); events_i[b] = 1'b0;
  endtask

  task automatic rx_word(input logic [31:0] ea, input logic ek, input string tag);
    @(negedge clk_i); recv_word_i[0] = 1'b1;
    @(negedge clk_i); recv_word_i[0] = 1'b0;
    check(recv_addr_o[31:0], ea, tag);
    check(32'(recv_keep_o[0]), 32'(ek), tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(32'(ack_o), 0, "R1 reset ack");
    check(32'(irq_o), 0, "R7 reset irq");
    rd(6'h00, 32'h0, "R3 reset status");
    rd(6'h10, 32'h1FF, "R4 reset burst all ones");
    rd(6'h01, 32'h0, "R5 reset flags");

    // R1 held strobe: ack toggles, write to unmapped offset
    @(negedge clk_i); stb_i = 1; we_i = 1; addr_i = 6'h06; wdata_i = 32'hFFFF_FFFF;
    @(negedge clk_i); check(32'(ack_o), 1, "R1 held ack 1");
    @(negedge clk_i); check(32'(ack_o), 0, "R1 held ack 0");
    @(negedge clk_i); check(32'(ack_o), 1, "R1 held ack 1 again");
    #1 stb_i = 0; we_i = 0;
    rd(6'h06, 32'h0, "R11 unmapped 6 read zero");
    rd(6'h0F, 32'h0, "R11 unmapped 15 read zero");
    rd(6'h20, 32'h0, "R11 shared sub 2 zero");

    // R2 readback and channel isolation
    wr(6'h02, 32'h5A); wr(6'h03, 32'h1000); wr(6'h05, 32'h33);
    wr(6'h12, 32'h11); wr(6'h0D, 32'h5);
    rd(6'h02, 32'h5A, "R2 ch0 dest");
    rd(6'h03, 32'h1000, "R2 ch0 send ptr");
    rd(6'h05, 32'h33, "R2 ch0 hdr");
    rd(6'h12, 32'h11, "R2 ch1 dest");
    rd(6'h0D, 32'h5, "R2 ch0 recv ctrl");
    check(32'(recv_ctrl_o[7:0]), 32'h5, "R2 recv ctrl out");
    check(32'(send_dest_o[15:8]), 32'h11, "R2 ch1 dest out");
    check(32'(send_dest_o[7:0]), 32'h5A, "R2 ch0 dest out");

    // R8 size write idle starts send
    wr(6'h04, 32'h40);
    check(32'(send_start_o), 32'h1, "R8 start pulse");
    @(negedge clk_i);
    check(32'(send_start_o), 32'h0, "R8 start single cycle");
    check(32'(send_size_o[9:0]), 32'h40, "R8 size out");

    // R8 busy: writes ignored, size write flags bad request
    send_busy_i = 2'b01;
    wr(6'h02, 32'h77);
    rd(6'h02, 32'h5A, "R8 dest write ignored while busy");
    wr(6'h04, 32'h80);
    check(32'(send_start_o), 32'h0, "R8 no start while busy");
    rd(6'h04, 32'h40, "R8 size kept while busy");
    rd(6'h01, 32'h2001, "R5 bad request and send busy bits");

    // R4 burst write blocked while busy
    wr(6'h10, 32'h10);
    rd(6'h10, 32'h1FF, "R4 burst blocked while busy");
    send_busy_i = 2'b00;
    wr(6'h10, 32'h10);
    rd(6'h10, 32'h10, "R4 burst written when idle");
    check(32'(burst_o), 32'h10, "R4 burst out");

    // R6 W1C of bad request
    wr(6'h01, 32'h2000);
    rd(6'h01, 32'h0, "R6 clear bad request");

    // R6/R7 sent event on ch1
    pulse_evt(7);
    rd(6'h11, 32'h40, "R6 sent flag set");
    check(32'(irq_o), 0, "R7 no irq without enable");
    wr(6'h11, 32'h4);
    check(32'(irq_o), 1, "R7 irq with sent enable");
    rd(6'h11, 32'h44, "R5 flag and enable bits");
    rd(6'h00, 32'h1, "R3 status any sent");
    @(negedge clk_i); events_i[7] = 1'b1;
    wr(6'h11, 32'h44);
    events_i[7] = 1'b0;
    rd(6'h11, 32'h44, "R6 event wins over clear");
    wr(6'h11, 32'h44);
    rd(6'h11, 32'h04, "R6 clear sent");
    check(32'(irq_o), 0, "R7 irq cleared");

    // R7 error path on ch0
    wr(6'h01, 32'h20);
    pulse_evt(3);
    check(32'(irq_o), 1, "R7 error irq");
    rd(6'h01, 32'h220, "R5 overflow flag bit 9");
    rd(6'h00, 32'h8, "R3 status any error");
    wr(6'h01, 32'h200);
    check(32'(irq_o), 0, "R7 error irq cleared");

    // R9 header capture on ch1
    hdr_src_i = 8'h2C; hdr_class_i = 2'd3; hdr_data_i = 8'hA5; precap_i = 8'h7E;
    @(negedge clk_i); hdr_save_i = 2'b10;
    @(negedge clk_i); hdr_save_i = 2'b00;
    rd(6'h18, 32'hA503_002C, "R9 source pack");
    rd(6'h1E, 32'h7E, "R9 precap");
    rd(6'h08, 32'h0, "R9 ch0 source untouched");
    rx_size_i = 12'h123;
    pulse_evt(9);
    rd(6'h1A, 32'h123, "R9 received size");
    wr(6'h11, 32'h100);

    // R3 grant indices
    send_grant_i = 1'b1;
    rd(6'h00, 32'h20, "R3 send grant index");

    // R10 receive addressing ch0
    wr(6'h09, 32'h2000); wr(6'h0B, 32'd4); wr(6'h0C, 32'd2);
    @(negedge clk_i); recv_begin_i[0] = 1'b1;
    @(negedge clk_i); recv_begin_i[0] = 1'b0;
    check(recv_addr_o[31:0], 32'h2008, "R10 start index");
    check(32'(recv_keep_o[0]), 1, "R10 keep at start");
    rx_word(32'h200C, 1'b1, "R10 word 1");
    rx_word(32'h2000, 1'b1, "R10 wrap to pointer");
    rx_word(32'h2004, 1'b1, "R10 word 3");
    rx_word(32'h2008, 1'b0, "R10 limit reached discard");
    rx_word(32'h2008, 1'b0, "R10 discard holds address");

    repeat (3) @(negedge clk_i);
    check(32'(exp_q.size()), 0, "R1 all reads acknowledged");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule